// File: doc/BRIEF.md
# Hybrid-Mapped Stacked-DRAM Cache Lookup Controller

This block handles lookup and placement for a set-associative DRAM cache whose tags live in DRAM. A small direct-mapped SRAM tag cache sits in front of it. Each request is classified when it is looked up. If the tag cache does not hold the request's set, the request is a *leading* access. If the tag cache does hold the set, the request is a *following* access.

A leading access sends one combined command to DRAM. That command brings the whole set's tags into the tag cache and reads the data of one fixed way at the same time, so the controller never waits for a tag read before the data read. The fixed way is the tag's low bits. A following access already has its tags in SRAM. It can hit in any way, and on a miss it is placed in a way chosen by a separate replacement block.

Each stored line records whether it was placed as leading or following. The request/response port accepts one request at a time. Each response reports hit or miss, the way, the access class and the stored type of the line.

The finite-state machine has seven states:

| State | Purpose |
|---|---|
| IDLE | Accept a request |
| LOOKUP | Classify the request |
| LEAD_RD | Combined tag-batch and static-way read |
| DATA_RD | Data read of a known way |
| VICT | Wait for a victim way |
| FILL | Write the line |
| RESP | One-cycle response |

The transitions are:

| From | To | Condition |
|---|---|---|
| IDLE | LOOKUP | Request accepted |
| LOOKUP | LEAD_RD | Leading access |
| LOOKUP | DATA_RD | Following hit |
| LOOKUP | VICT | Following miss |
| LEAD_RD | RESP | Static way hits |
| LEAD_RD | DATA_RD | Another way hits |
| LEAD_RD | FILL | Miss |
| DATA_RD | RESP | Done |
| VICT | FILL | Victim way arrives |
| FILL | RESP | Done |
| RESP | IDLE | Always |

Top module: `hybrid_map_ctrl`

## Requirements
- R1: After reset, `req_ready`=1 and `resp_valid`, `dram_cmd_valid` and `vict_req` are 0. No line is valid and the tag cache is empty, so the first access is a leading miss.
- R2: An address is laid out as {tag, set, 6-bit line offset}, and the offset has no effect. If the set is not resident in the tag cache:
  - the response has `resp_lead`=1;
  - the first command has op 0 (combined tag-batch and data read), with the request's set on `dram_cmd_set`.
- R3: The static way of a leading access is tag mod WAYS (the tag's low bits), and this is the way on `dram_cmd_way` for op 0. If that way holds the tag, the response is a hit on that way after this single command.
- R4: The tag cache is direct-mapped, with index set mod TC_ENTRIES.
  - A completed op 0 installs the set and evicts any other set with the same index.
  - An access to a resident set has `resp_lead`=0 and issues no op 0.
- R5: A following hit issues one data read (op 1) on the matching way, then responds with hit=1 and that way.
- R6: A following miss raises `vict_req` with `vict_set`=set until `vict_ready`. It then issues a fill (op 2) on `vict_way` and responds with hit=0 and way=`vict_way`.
- R7: A leading miss raises no victim request. It fills the static way (op 2) and responds with hit=0 and way=static.
- R8: A leading access whose tag is held in a way other than the static way issues op 0, then op 1 on the matching way. It responds with hit=1 on that way.
- R9: Each filled line stores a type bit: 1 if it was placed by a leading access, 0 if by a following access. `resp_line_lead` shows the type bit of the responded way; on a miss this equals `resp_lead`.
- R10: Only one command or victim request is outstanding at a time. A command holds its op, set and way unchanged until `dram_done`.
- R11: `req_ready` is 1 only while idle, and a request is taken on `req_valid` with `req_ready`. `resp_valid` is a single-cycle pulse per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Byte address {tag, set, offset} |
| req_ready | output | 1 | Controller idle, request accepted |
| resp_valid | output | 1 | Response pulse |
| resp_hit | output | 1 | 1 = hit |
| resp_way | output | WAY_W | Way hit or filled |
| resp_lead | output | 1 | 1 = leading access |
| resp_line_lead | output | 1 | Stored type bit of responded line |
| dram_cmd_valid | output | 1 | DRAM command present |
| dram_cmd_op | output | 2 | 0 tag-batch+data, 1 data read, 2 fill |
| dram_cmd_set | output | SET_W | Target set |
| dram_cmd_way | output | WAY_W | Target way |
| dram_done | input | 1 | Command completes |
| vict_req | output | 1 | Victim way requested |
| vict_set | output | SET_W | Set needing a victim |
| vict_ready | input | 1 | Victim way valid |
| vict_way | input | WAY_W | Victim way from replacement block |

## Verification
Two functions can fall in the same cycle:
- the tag-cache install that completes a leading fetch;
- the eviction of another set that shares its tag-cache index.

The bench provokes this by alternating requests between sets 2 and 4, which share an index with two entries. It judges the result by the class of the next access to each set: the newly installed set must be following, and the displaced set must be leading again. When the displaced set returns as a leading access, the bench checks both paths. If its tag sits in a way other than the static way, the response must follow the combined read with a data read. If its tag sits in the static way, the response must be a single-command hit.

// File: rtl/hm_pkg.sv
`timescale 1ns/1ps
package hm_pkg;
    typedef enum logic [1:0] {
        OP_LEAD_TD = 2'd0,
        OP_DATA    = 2'd1,
        OP_FILL    = 2'd2
    } hm_op_e;

    typedef enum logic [2:0] {
        S_IDLE, S_LOOKUP, S_LEAD_RD, S_DATA_RD, S_VICT, S_FILL, S_RESP
    } hm_state_e;
endpackage

// File: rtl/hm_tagstore.sv
`timescale 1ns/1ps
module hm_tagstore #(
    parameter int SETS  = 8,
    parameter int WAYS  = 4,
    parameter int TAG_W = 6,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SET_W-1:0]      rd_set,
    output logic [WAYS-1:0]       rd_vld,
    output logic [WAYS-1:0]       rd_typ,
    output logic [WAYS*TAG_W-1:0] rd_tags,
    input  logic                  wr_en,
    input  logic [SET_W-1:0]      wr_set,
    input  logic [WAY_W-1:0]      wr_way,
    input  logic [TAG_W-1:0]      wr_tag,
    input  logic                  wr_lead
);
    logic [WAYS-1:0]       vld_q [SETS];
    logic [WAYS-1:0]       typ_q [SETS];
    logic [WAYS*TAG_W-1:0] tag_q [SETS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                typ_q[s] <= '0;
                tag_q[s] <= '0;
            end
        end else if (wr_en) begin
            vld_q[wr_set][wr_way]                    <= 1'b1;
            typ_q[wr_set][wr_way]                    <= wr_lead;
            tag_q[wr_set][wr_way*TAG_W +: TAG_W]     <= wr_tag;
        end
    end

    assign rd_vld  = vld_q[rd_set];
    assign rd_typ  = typ_q[rd_set];
    assign rd_tags = tag_q[rd_set];
endmodule

// File: rtl/hm_waymatch.sv
`timescale 1ns/1ps
module hm_waymatch #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 6,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]       vld,
    input  logic [WAYS*TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]      key,
    output logic                  hit,
    output logic [WAY_W-1:0]      way
);
    logic [WAYS-1:0] eq;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign eq[w] = vld[w] && (tags[w*TAG_W +: TAG_W] == key);
    end

    always_comb begin
        hit = |eq;
        way = '0;
        for (int w = WAYS-1; w >= 0; w--) begin
            if (eq[w]) way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/hm_tagcache.sv
`timescale 1ns/1ps
module hm_tagcache #(
    parameter int SETS       = 8,
    parameter int TC_ENTRIES = 2,
    localparam int SET_W = $clog2(SETS),
    localparam int TC_W  = $clog2(TC_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] lk_set,
    output logic             lk_hit,
    input  logic             ins_en,
    input  logic [SET_W-1:0] ins_set
);
    logic             ent_v [TC_ENTRIES];
    logic [SET_W-1:0] ent_s [TC_ENTRIES];
    logic [TC_W-1:0]  lk_idx, ins_idx;

    assign lk_idx  = lk_set[TC_W-1:0];
    assign ins_idx = ins_set[TC_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < TC_ENTRIES; e++) begin
                ent_v[e] <= 1'b0;
                ent_s[e] <= '0;
            end
        end else if (ins_en) begin
            ent_v[ins_idx] <= 1'b1;
            ent_s[ins_idx] <= ins_set;
        end
    end

    assign lk_hit = ent_v[lk_idx] && (ent_s[lk_idx] == lk_set);
endmodule

// File: rtl/hybrid_map_ctrl.sv
`timescale 1ns/1ps
module hybrid_map_ctrl
    import hm_pkg::*;
#(
    parameter int SETS       = 8,
    parameter int WAYS       = 4,
    parameter int TAG_W      = 6,
    parameter int TC_ENTRIES = 2,
    parameter int LINE_BYTES = 64,
    localparam int SET_W  = $clog2(SETS),
    localparam int WAY_W  = $clog2(WAYS),
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int ADDR_W = TAG_W + SET_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [WAY_W-1:0]  resp_way,
    output logic              resp_lead,
    output logic              resp_line_lead,
    output logic              dram_cmd_valid,
    output logic [1:0]        dram_cmd_op,
    output logic [SET_W-1:0]  dram_cmd_set,
    output logic [WAY_W-1:0]  dram_cmd_way,
    input  logic              dram_done,
    output logic              vict_req,
    output logic [SET_W-1:0]  vict_set,
    input  logic              vict_ready,
    input  logic [WAY_W-1:0]  vict_way
);
    hm_state_e state, nxt;

    logic [TAG_W-1:0] r_tag;
    logic [SET_W-1:0] r_set;
    logic [WAY_W-1:0] r_way;
    logic             r_hit, r_lead;

    logic [WAYS-1:0]       ts_vld, ts_typ;
    logic [WAYS*TAG_W-1:0] ts_tags;
    logic                  m_hit, tc_hit;
    logic [WAY_W-1:0]      m_way, stat_way;
    logic                  fill_wr, tc_ins;
    logic                  unused_offset;

    assign unused_offset = ^req_addr[OFF_W-1:0];
    assign stat_way      = r_tag[WAY_W-1:0];
    assign fill_wr       = (state == S_FILL) && dram_done;
    assign tc_ins        = (state == S_LEAD_RD) && dram_done;

    hm_tagstore #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_set(r_set), .rd_vld(ts_vld), .rd_typ(ts_typ), .rd_tags(ts_tags),
        .wr_en(fill_wr), .wr_set(r_set), .wr_way(r_way),
        .wr_tag(r_tag), .wr_lead(r_lead)
    );

    hm_waymatch #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .vld(ts_vld), .tags(ts_tags), .key(r_tag), .hit(m_hit), .way(m_way)
    );

    hm_tagcache #(.SETS(SETS), .TC_ENTRIES(TC_ENTRIES)) u_tc (
        .clk(clk), .rst_n(rst_n),
        .lk_set(r_set), .lk_hit(tc_hit),
        .ins_en(tc_ins), .ins_set(r_set)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:    if (req_valid) nxt = S_LOOKUP;
            S_LOOKUP: begin
                if (!tc_hit)    nxt = S_LEAD_RD;
                else if (m_hit) nxt = S_DATA_RD;
                else            nxt = S_VICT;
            end
            S_LEAD_RD: if (dram_done) begin
                if (m_hit && (m_way == stat_way)) nxt = S_RESP;
                else if (m_hit)                   nxt = S_DATA_RD;
                else                              nxt = S_FILL;
            end
            S_DATA_RD: if (dram_done)  nxt = S_RESP;
            S_VICT:    if (vict_ready) nxt = S_FILL;
            S_FILL:    if (dram_done)  nxt = S_RESP;
            S_RESP:    nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    // request datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_tag  <= '0;
            r_set  <= '0;
            r_way  <= '0;
            r_hit  <= 1'b0;
            r_lead <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (req_valid) begin
                    r_tag  <= req_addr[ADDR_W-1 -: TAG_W];
                    r_set  <= req_addr[OFF_W +: SET_W];
                    r_hit  <= 1'b0;
                    r_lead <= 1'b0;
                end
                S_LOOKUP: begin
                    r_lead <= !tc_hit;
                    if (!tc_hit)    r_way <= stat_way;
                    else if (m_hit) r_way <= m_way;
                end
                S_LEAD_RD: if (dram_done) begin
                    if (m_hit && (m_way == stat_way)) r_hit <= 1'b1;
                    else if (m_hit)                   r_way <= m_way;
                end
                S_DATA_RD: if (dram_done)  r_hit <= 1'b1;
                S_VICT:    if (vict_ready) r_way <= vict_way;
                S_FILL, S_RESP: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready      = 1'b0;
        resp_valid     = 1'b0;
        dram_cmd_valid = 1'b0;
        dram_cmd_op    = OP_DATA;
        vict_req       = 1'b0;
        unique case (state)
            S_IDLE:    req_ready = 1'b1;
            S_LOOKUP:  ;
            S_LEAD_RD: begin dram_cmd_valid = 1'b1; dram_cmd_op = OP_LEAD_TD; end
            S_DATA_RD: begin dram_cmd_valid = 1'b1; dram_cmd_op = OP_DATA;    end
            S_VICT:    vict_req = 1'b1;
            S_FILL:    begin dram_cmd_valid = 1'b1; dram_cmd_op = OP_FILL;    end
            S_RESP:    resp_valid = 1'b1;
            default:   ;
        endcase
    end

    assign dram_cmd_set   = r_set;
    assign dram_cmd_way   = r_way;
    assign vict_set       = r_set;
    assign resp_hit       = r_hit;
    assign resp_way       = r_way;
    assign resp_lead      = r_lead;
    assign resp_line_lead = ts_typ[r_way];
endmodule

// File: rtl/hm_ctrl_checker.sv
`timescale 1ns/1ps
module hm_ctrl_checker #(
    parameter int SETS       = 8,
    parameter int WAYS       = 4,
    parameter int TAG_W      = 6,
    parameter int LINE_BYTES = 64,
    localparam int SET_W  = $clog2(SETS),
    localparam int WAY_W  = $clog2(WAYS),
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int ADDR_W = TAG_W + SET_W + OFF_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_ready,
    input logic              resp_valid,
    input logic              resp_hit,
    input logic [WAY_W-1:0]  resp_way,
    input logic              resp_lead,
    input logic              resp_line_lead,
    input logic              dram_cmd_valid,
    input logic [1:0]        dram_cmd_op,
    input logic [SET_W-1:0]  dram_cmd_set,
    input logic [WAY_W-1:0]  dram_cmd_way,
    input logic              dram_done,
    input logic              vict_req,
    input logic [SET_W-1:0]  vict_set,
    input logic              vict_ready
);
    logic [TAG_W-1:0] cap_tag;
    logic [SET_W-1:0] cap_set;
    logic             unused_chk_offset;

    assign unused_chk_offset = ^req_addr[OFF_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_tag <= '0;
            cap_set <= '0;
        end else if (req_valid && req_ready) begin
            cap_tag <= req_addr[ADDR_W-1 -: TAG_W];
            cap_set <= req_addr[OFF_W +: SET_W];
        end
    end

    a_r10_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        dram_cmd_valid && !dram_done |=> dram_cmd_valid && $stable(dram_cmd_op)
            && $stable(dram_cmd_set) && $stable(dram_cmd_way));

    a_r10_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        !(vict_req && dram_cmd_valid));

    a_r11_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    a_r11_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !resp_valid && !dram_cmd_valid && !vict_req);

    a_r3_lead_static_way: assert property (@(posedge clk) disable iff (!rst_n)
        dram_cmd_valid && dram_cmd_op == 2'd0 |->
            dram_cmd_way == cap_tag[WAY_W-1:0] && dram_cmd_set == cap_set);

    a_r7_lead_miss_static: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && resp_lead && !resp_hit |-> resp_way == cap_tag[WAY_W-1:0]);

    a_r6_vict_hold: assert property (@(posedge clk) disable iff (!rst_n)
        vict_req && !vict_ready |=> vict_req && $stable(vict_set));

    a_r9_miss_type: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && !resp_hit |-> resp_line_lead == resp_lead);
endmodule

bind hybrid_map_ctrl hm_ctrl_checker #(
    .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .LINE_BYTES(LINE_BYTES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .resp_way(resp_way), .resp_lead(resp_lead), .resp_line_lead(resp_line_lead),
    .dram_cmd_valid(dram_cmd_valid), .dram_cmd_op(dram_cmd_op),
    .dram_cmd_set(dram_cmd_set), .dram_cmd_way(dram_cmd_way),
    .dram_done(dram_done), .vict_req(vict_req), .vict_set(vict_set),
    .vict_ready(vict_ready)
);

// File: tb/tb_hybrid_map_ctrl.sv
`timescale 1ns/1ps
module tb_hybrid_map_ctrl;
    localparam int SETS = 8, WAYS = 4, TAG_W = 6, TCE = 2, LINE_BYTES = 64;
    localparam int SET_W = $clog2(SETS), WAY_W = $clog2(WAYS);
    localparam int OFF_W = $clog2(LINE_BYTES), ADDR_W = TAG_W + SET_W + OFF_W;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic req_ready, resp_valid, resp_hit, resp_lead, resp_line_lead;
    logic [WAY_W-1:0] resp_way;
    logic dram_cmd_valid;
    logic [1:0] dram_cmd_op;
    logic [SET_W-1:0] dram_cmd_set, vict_set;
    logic [WAY_W-1:0] dram_cmd_way;
    logic dram_done = 0, vict_req, vict_ready = 0;
    logic [WAY_W-1:0] vict_way = '0;

    always #2.5 clk = ~clk;

    hybrid_map_ctrl #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W),
                      .TC_ENTRIES(TCE), .LINE_BYTES(LINE_BYTES)) dut (.*);

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    bit m_vld [SETS][WAYS];
    bit m_typ [SETS][WAYS];
    int m_tag [SETS][WAYS];
    bit tc_v [TCE];
    int tc_s [TCE];

    int cmd_n = 0, vict_n = 0, vict_given = 0, vict_s = 0;
    int cmd_op [8], cmd_way [8], cmd_set [8];

    task automatic chk(string rq, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    // behavioural DRAM side
    initial begin
        forever begin
            @(negedge clk);
            dram_done = 0;
            if (dram_cmd_valid) begin
                if (cmd_n < 8) begin
                    cmd_op[cmd_n] = int'(dram_cmd_op);
                    cmd_way[cmd_n] = int'(dram_cmd_way);
                    cmd_set[cmd_n] = int'(dram_cmd_set);
                end
                cmd_n++;
                repeat ($urandom % 3) @(negedge clk);
                dram_done = 1;
            end
        end
    end

    // behavioural replacement block
    initial begin
        forever begin
            @(negedge clk);
            vict_ready = 0;
            if (vict_req) begin
                vict_s = int'(vict_set);
                repeat ($urandom % 3) @(negedge clk);
                vict_way = WAY_W'($urandom % WAYS);
                vict_given = int'(vict_way);
                vict_n++;
                vict_ready = 1;
            end
        end
    end

    task automatic do_req(int tag, int set);
        int n, idx, st, m, e_way, e_ll, e_ncmd;
        bit lead, hit, busy_rdy;
        int e_op [2], e_w [2];
        n = 0;
        while (!req_ready && n < 50) begin @(negedge clk); n++; end
        cmd_n = 0; vict_n = 0;
        req_addr = {TAG_W'(tag), SET_W'(set), OFF_W'($urandom)};
        req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        n = 0; busy_rdy = 0;
        while (!resp_valid && n < 200) begin
            if (req_ready) busy_rdy = 1;
            @(negedge clk); n++;
        end
        chk("R11", "ready low while busy", int'(busy_rdy), 0);
        if (!resp_valid) begin
            chk("R11", "response timeout", 0, 1);
            return;
        end
        // expected outcome from the bench model
        idx = set % TCE;
        lead = !(tc_v[idx] && tc_s[idx] == set);
        st = tag % WAYS;
        m = -1;
        for (int w = 0; w < WAYS; w++) if (m_vld[set][w] && m_tag[set][w] == tag) m = w;
        hit = (m >= 0);
        e_ncmd = 0;
        if (lead) begin
            e_op[0] = 0; e_w[0] = st; e_ncmd = 1;
            if (hit && m == st) e_way = st;
            else if (hit) begin e_op[1] = 1; e_w[1] = m; e_ncmd = 2; e_way = m; end
            else begin e_op[1] = 2; e_w[1] = st; e_ncmd = 2; e_way = st; end
        end else if (hit) begin
            e_op[0] = 1; e_w[0] = m; e_ncmd = 1; e_way = m;
        end else begin
            e_op[0] = 2; e_w[0] = vict_given; e_ncmd = 1; e_way = vict_given;
        end
        e_ll = hit ? int'(m_typ[set][m]) : int'(lead);

        chk(lead ? "R2" : "R4", "resp_lead", int'(resp_lead), int'(lead));
        chk(hit ? (lead ? "R8" : "R5") : (lead ? "R7" : "R6"), "resp_hit", int'(resp_hit), int'(hit));
        chk(lead ? "R3" : "R5", "resp_way", int'(resp_way), e_way);
        chk("R9", "resp_line_lead", int'(resp_line_lead), e_ll);
        chk("R10", "command count", cmd_n, e_ncmd);
        chk(lead ? "R7" : "R6", "victim requests", vict_n, (!lead && !hit) ? 1 : 0);
        if (!lead && !hit) chk("R6", "vict_set", vict_s, set);
        for (int i = 0; i < e_ncmd && i < cmd_n; i++) begin
            chk("R10", "cmd op", cmd_op[i], e_op[i]);
            chk("R3", "cmd way", cmd_way[i], e_w[i]);
            chk("R2", "cmd set", cmd_set[i], set);
        end
        // model update
        if (lead) begin tc_v[idx] = 1; tc_s[idx] = set; end
        if (!hit) begin
            m_vld[set][e_way] = 1; m_tag[set][e_way] = tag; m_typ[set][e_way] = lead;
        end
        @(negedge clk);
        chk("R11", "resp pulse width", int'(resp_valid), 0);
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1bad5eed));
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "req_ready", int'(req_ready), 1);
        chk("R1", "resp_valid", int'(resp_valid), 0);
        chk("R1", "dram_cmd_valid", int'(dram_cmd_valid), 0);
        chk("R1", "vict_req", int'(vict_req), 0);
        // directed sequence
        do_req(5, 2);  // R1/R7: leading miss, static way 1
        do_req(5, 2);  // R5/R9: following hit, type 1
        do_req(9, 2);  // R6: following miss via victim
        do_req(9, 2);  // R5: following hit, type 0
        do_req(7, 4);  // R4: aliases set 2 and evicts it
        do_req(9, 2);  // R8 unless victim chose static way
        do_req(5, 2);  // R4: following again
        do_req(7, 4);  // R3: leading static-way hit
        do_req(5, 2);  // R3/R8: leading again
        // constrained random
        for (int i = 0; i < 400; i++) do_req(int'($urandom % 8), int'($urandom % SETS));
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule